// File: doc/BRIEF.md
# Breakpoint value match comparator

This block keeps a bank of up to sixteen 64-bit breakpoint value slots and compares each one, every cycle and without a clock delay, against the state of the executing core. A four-bit type code for each slot decides how the stored bits are read. The slot can hold an instruction address, a single context identifier, a pair of context identifiers, a virtual-machine identifier (VMID), or a VMID together with a context identifier. The result is a 16-bit vector with one hit bit per slot. Linking between breakpoints, address masking and raising an exception are left to the logic around the block.

Software writes a slot through a simple write port and reads it back through an index-addressed read port. The readback is shaped by the slot's current type. Reserved bits read as zero. In address layout the upper sign field reads as copies of the top address bit. An index at or above the number of built slots (`NUM_BP`) is flagged as undefined, stores nothing and reads zero.

The decode of each slot is a small set of named layout states, chosen by type bits [3:1]: `LAY_ADDR` (000), `LAY_CTX_AUTO` (001), `LAY_CTX_L1` (011), `LAY_CTX_L2` (110), `LAY_VMID` (100), `LAY_VMID_CTX` (101), `LAY_CTX_PAIR` (111) and `LAY_NONE` (010). The only sequential transition is the slot register loading write data on a clock edge. Everything else follows its inputs in the same cycle.

Top module: `bp_value_match`

## Requirements
- R1: After reset every slot holds zero, so every implemented slot reads back 0 in every layout and `match_o` is 0 while all enables are clear.
- R2: With `wr_en` high and `wr_idx` below `NUM_BP`, the slot at that index takes `wr_data` on the next rising edge. No other slot changes. With type code 4'b1110, the readback returns all 64 stored bits.
- R3: When an index is at or above `NUM_BP`: `rd_undef_o` is high whenever `rd_idx` is such an index, and `rd_data_o` is then 0. `wr_undef_o` is high when `wr_en` targets such an index, and that write changes no slot. Match bits of unbuilt slots are 0.
- R4: A slot whose `bp_enable` bit is 0 drives 0 on its `match_o` bit, whatever its value and type.
- R5: Type bit 0 has no effect on the compare or on the readback. Codes differing only in bit 0 behave the same.
- R6: In address layout (type [3:1]=000), bits [T:2] of the slot are compared with `cur_addr[T:2]`, with T=48 (or 52 when `LARGE_VA` is set). Bits [1:0] and the bits above T take no part in the compare.
- R7: With `LARGE_VA` clear, a difference in bits [52:49] between slot and address does not prevent a match.
- R8: In address layout, readback bits [1:0] are 0 and every bit above T equals stored bit T.
- R9: For type 001, slot bits [31:0] are compared with `ctx_l2` when `host_ext_en` is 1 and either `cur_el` is 2, or `cur_el` is 0 with `trap_general` and `el2_enabled` both 1. Otherwise they are compared with `ctx_l1`.
- R10: Type 011 compares bits [31:0] with `ctx_l1` only. Type 110 compares bits [63:32] with `ctx_l2`. Type 111 needs both bits [63:32] equal to `ctx_l2` and bits [31:0] equal to `ctx_l1`.
- R11: A VMID compare always checks bits [39:32] against `cur_vmid[7:0]`. Bits [47:40] against `cur_vmid[15:8]` are added only when `VMID16_EN`, `vmid_wide_ctl` and `el2_is_64` are all 1. Otherwise bits [47:40] are ignored and read back as 0.
- R12: Type 101 matches only when the VMID compare and the compare of bits [31:0] with `ctx_l1` both succeed.
- R13: Type code 010 (bits [3:1]) never matches and reads back 0.
- R14: In the context and VMID layouts, every bit the layout does not use reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the slot registers |
| rst_n | input | 1 | Active-low reset, clears all slots |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Slot index for the write |
| wr_data | input | 64 | Value to store |
| wr_undef_o | output | 1 | Write targets an unbuilt slot |
| rd_idx | input | 4 | Slot index for readback |
| rd_data_o | output | 64 | Type-shaped readback of the indexed slot |
| rd_undef_o | output | 1 | Read index names an unbuilt slot |
| bp_enable | input | 16 | Per-slot enable, bit i for slot i |
| bp_type | input | 64 | Per-slot type code, bits [4i+3:4i] for slot i |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| host_ext_en | input | 1 | Host-virtualization extension enabled |
| trap_general | input | 1 | Level-0 execution routed to level 2 |
| el2_enabled | input | 1 | Level 2 enabled in the current security state |
| vmid_wide_ctl | input | 1 | VMID-size control, 1 selects 16 bits |
| el2_is_64 | input | 1 | Level 2 runs in 64-bit state |
| cur_addr | input | 64 | Address of the current instruction |
| ctx_l1 | input | 32 | Level-1 context identifier |
| ctx_l2 | input | 32 | Level-2 context identifier |
| cur_vmid | input | 16 | Current VMID |
| match_o | output | 16 | Per-slot hit vector |

## Verification
`match_o` and `rd_data_o` are combinational functions of the stored slots and the current inputs. They are due in the same cycle an input changes, and the bench samples them one nanosecond after driving on a falling edge. A written value counts from the first rising edge on which `wr_en` is seen. Each write task holds the strobe across exactly one rising edge and checks only from the following falling edge. The undefined flags are combinational and are checked in the same settle window as the index that causes them.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int BP_SLOTS_MAX = 16;
    localparam int IDX_W        = $clog2(BP_SLOTS_MAX);
    localparam int VAL_W        = 64;
    localparam int CTX_W        = 32;
    localparam int VMID_W       = 16;
    localparam int TYPE_W       = 4;
    localparam int SEL_W        = TYPE_W - 1;

    typedef enum logic [2:0] {
        LAY_ADDR,
        LAY_CTX_AUTO,
        LAY_CTX_L1,
        LAY_CTX_L2,
        LAY_VMID,
        LAY_VMID_CTX,
        LAY_CTX_PAIR,
        LAY_NONE
    } layout_e;

    // Only type bits [3:1] reach this decode; bit 0 never shapes the layout.
    function automatic layout_e bp_decode(input logic [SEL_W-1:0] sel);
        layout_e lay;
        unique case (sel)
            3'b000:  lay = LAY_ADDR;
            3'b001:  lay = LAY_CTX_AUTO;
            3'b011:  lay = LAY_CTX_L1;
            3'b110:  lay = LAY_CTX_L2;
            3'b100:  lay = LAY_VMID;
            3'b101:  lay = LAY_VMID_CTX;
            3'b111:  lay = LAY_CTX_PAIR;
            default: lay = LAY_NONE;
        endcase
        return lay;
    endfunction
endpackage

// File: rtl/bp_ctx_steer.sv
module bp_ctx_steer
    import bp_pkg::*;
#(
    parameter bit VMID16_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cur_el,
    input  logic             host_ext_en,
    input  logic             trap_general,
    input  logic             el2_enabled,
    input  logic             vmid_wide_ctl,
    input  logic             el2_is_64,
    input  logic [CTX_W-1:0] ctx_l1,
    input  logic [CTX_W-1:0] ctx_l2,
    output logic [CTX_W-1:0] ctx_auto,
    output logic             vmid_wide
);
    logic host_level_ctx;

    always_comb begin
        host_level_ctx = host_ext_en &&
                         ((cur_el == 2'd2) ||
                          (cur_el == 2'd0 && trap_general && el2_enabled));
        ctx_auto  = host_level_ctx ? ctx_l2 : ctx_l1;
        vmid_wide = VMID16_EN && vmid_wide_ctl && el2_is_64;
    end

    // R9: without the host extension the automatic context is always level 1
    a_r9_l1_without_host: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ext_en |-> ctx_auto == ctx_l1);

    // R11: the VMID stays 8 bits while the size control is clear
    a_r11_narrow_vmid: assert property (@(posedge clk) disable iff (!rst_n)
        !vmid_wide_ctl |-> !vmid_wide);
endmodule

// File: rtl/bp_slot.sv
module bp_slot
    import bp_pkg::*;
#(
    parameter bit LARGE_VA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              enable,
    input  logic [SEL_W-1:0]  type_sel,
    input  logic [VAL_W-1:0]  cur_addr,
    input  logic [CTX_W-1:0]  ctx_auto,
    input  logic [CTX_W-1:0]  ctx_l1,
    input  logic [CTX_W-1:0]  ctx_l2,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic              vmid_wide,
    output logic              hit,
    output logic [VAL_W-1:0]  rdback
);
    localparam int ADDR_TOP = LARGE_VA ? 52 : 48;
    localparam int SIGN_W   = VAL_W - 1 - ADDR_TOP;

    logic [VAL_W-1:0] val_q;
    layout_e          lay;
    logic             raw_hit;
    logic             addr_eq, lo_l1_eq, lo_auto_eq, hi_l2_eq, vmid_eq;
    logic [7:0]       vmid_hi_rb;
    logic             unused_addr;

    assign unused_addr = ^cur_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (wr_hit) val_q <= wr_data;
    end

    always_comb begin
        lay        = bp_decode(type_sel);
        addr_eq    = val_q[ADDR_TOP:2] == cur_addr[ADDR_TOP:2];
        lo_l1_eq   = val_q[31:0] == ctx_l1;
        lo_auto_eq = val_q[31:0] == ctx_auto;
        hi_l2_eq   = val_q[63:32] == ctx_l2;
        vmid_eq    = (val_q[39:32] == cur_vmid[7:0]) &&
                     (!vmid_wide || val_q[47:40] == cur_vmid[15:8]);
        vmid_hi_rb = vmid_wide ? val_q[47:40] : 8'h00;
    end

    always_comb begin
        raw_hit = 1'b0;
        rdback  = '0;
        unique case (lay)
            LAY_ADDR: begin
                raw_hit = addr_eq;
                rdback  = {{SIGN_W{val_q[ADDR_TOP]}}, val_q[ADDR_TOP:2], 2'b00};
            end
            LAY_CTX_AUTO: begin
                raw_hit = lo_auto_eq;
                rdback  = {32'h0, val_q[31:0]};
            end
            LAY_CTX_L1: begin
                raw_hit = lo_l1_eq;
                rdback  = {32'h0, val_q[31:0]};
            end
            LAY_CTX_L2: begin
                raw_hit = hi_l2_eq;
                rdback  = {val_q[63:32], 32'h0};
            end
            LAY_VMID: begin
                raw_hit = vmid_eq;
                rdback  = {16'h0, vmid_hi_rb, val_q[39:32], 32'h0};
            end
            LAY_VMID_CTX: begin
                raw_hit = vmid_eq && lo_l1_eq;
                rdback  = {16'h0, vmid_hi_rb, val_q[39:32], val_q[31:0]};
            end
            LAY_CTX_PAIR: begin
                raw_hit = hi_l2_eq && lo_l1_eq;
                rdback  = val_q;
            end
            LAY_NONE: begin
                raw_hit = 1'b0;
                rdback  = '0;
            end
        endcase
        hit = enable && raw_hit;
    end

    // R2: a selected write lands in the slot on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> val_q == $past(wr_data));

    // R13: the reserved code is silent on both outputs
    a_r13_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lay == LAY_NONE |-> !hit && rdback == '0);

    // R8: address readback has clear low bits and a uniform sign field
    a_r8_addr_sign: assert property (@(posedge clk) disable iff (!rst_n)
        lay == LAY_ADDR |-> rdback[1:0] == 2'b00 &&
            ((&rdback[VAL_W-1:ADDR_TOP]) || !(|rdback[VAL_W-1:ADDR_TOP])));
endmodule

// File: rtl/bp_value_match.sv
module bp_value_match
    import bp_pkg::*;
#(
    parameter int NUM_BP    = BP_SLOTS_MAX,
    parameter bit LARGE_VA  = 1'b0,
    parameter bit VMID16_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [VAL_W-1:0]           wr_data,
    output logic                       wr_undef_o,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [VAL_W-1:0]           rd_data_o,
    output logic                       rd_undef_o,
    input  logic [BP_SLOTS_MAX-1:0]    bp_enable,
    input  logic [BP_SLOTS_MAX*TYPE_W-1:0] bp_type,
    input  logic [1:0]                 cur_el,
    input  logic                       host_ext_en,
    input  logic                       trap_general,
    input  logic                       el2_enabled,
    input  logic                       vmid_wide_ctl,
    input  logic                       el2_is_64,
    input  logic [VAL_W-1:0]           cur_addr,
    input  logic [CTX_W-1:0]           ctx_l1,
    input  logic [CTX_W-1:0]           ctx_l2,
    input  logic [VMID_W-1:0]          cur_vmid,
    output logic [BP_SLOTS_MAX-1:0]    match_o
);
    localparam int CMP_W = IDX_W + 1;

    logic [CTX_W-1:0]        ctx_auto;
    logic                    vmid_wide;
    logic [BP_SLOTS_MAX-1:0] slot_hit;
    logic [VAL_W-1:0]        slot_rb [BP_SLOTS_MAX];
    logic                    unused_cfg;

    assign unused_cfg = ^{bp_type, bp_enable};

    bp_ctx_steer #(.VMID16_EN(VMID16_EN)) u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_el        (cur_el),
        .host_ext_en   (host_ext_en),
        .trap_general  (trap_general),
        .el2_enabled   (el2_enabled),
        .vmid_wide_ctl (vmid_wide_ctl),
        .el2_is_64     (el2_is_64),
        .ctx_l1        (ctx_l1),
        .ctx_l2        (ctx_l2),
        .ctx_auto      (ctx_auto),
        .vmid_wide     (vmid_wide)
    );

    for (genvar g = 0; g < BP_SLOTS_MAX; g++) begin : g_slot
        if (g < NUM_BP) begin : g_impl
            bp_slot #(.LARGE_VA(LARGE_VA)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (wr_en && (wr_idx == IDX_W'(g))),
                .wr_data  (wr_data),
                .enable   (bp_enable[g]),
                .type_sel (bp_type[g*TYPE_W+1 +: SEL_W]),
                .cur_addr (cur_addr),
                .ctx_auto (ctx_auto),
                .ctx_l1   (ctx_l1),
                .ctx_l2   (ctx_l2),
                .cur_vmid (cur_vmid),
                .vmid_wide(vmid_wide),
                .hit      (slot_hit[g]),
                .rdback   (slot_rb[g])
            );
        end else begin : g_absent
            assign slot_hit[g] = 1'b0;
            assign slot_rb[g]  = '0;
        end
    end

    always_comb begin
        rd_undef_o = {1'b0, rd_idx} >= CMP_W'(NUM_BP);
        wr_undef_o = wr_en && ({1'b0, wr_idx} >= CMP_W'(NUM_BP));
        rd_data_o  = rd_undef_o ? '0 : slot_rb[rd_idx];
        match_o    = slot_hit;
    end

    // R4: no hit is ever reported for a disabled slot
    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & ~bp_enable) == '0);

    // R3: an unbuilt index reads as zero
    a_r3_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_undef_o |-> rd_data_o == '0);
endmodule

// File: tb/test_bp_value_match.sv
`timescale 1ns/100ps
module test_bp_value_match;
    localparam int NB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_undef_o;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data_o;
    logic        rd_undef_o;
    logic [15:0] bp_enable = '0;
    logic [63:0] bp_type = {16{4'b1110}};
    logic [1:0]  cur_el = 2'd1;
    logic        host_ext_en = 1'b0;
    logic        trap_general = 1'b0;
    logic        el2_enabled = 1'b0;
    logic        vmid_wide_ctl = 1'b0;
    logic        el2_is_64 = 1'b0;
    logic [63:0] cur_addr = '0;
    logic [31:0] ctx_l1 = '0;
    logic [31:0] ctx_l2 = '0;
    logic [15:0] cur_vmid = '0;
    logic [15:0] match_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bp_value_match #(.NUM_BP(NB)) i_bp_value_match (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_undef_o(wr_undef_o), .rd_idx(rd_idx), .rd_data_o(rd_data_o),
        .rd_undef_o(rd_undef_o), .bp_enable(bp_enable), .bp_type(bp_type),
        .cur_el(cur_el), .host_ext_en(host_ext_en), .trap_general(trap_general),
        .el2_enabled(el2_enabled), .vmid_wide_ctl(vmid_wide_ctl), .el2_is_64(el2_is_64),
        .cur_addr(cur_addr), .ctx_l1(ctx_l1), .ctx_l2(ctx_l2), .cur_vmid(cur_vmid),
        .match_o(match_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input logic [63:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic setup(input int idx, input logic [3:0] t, input logic en);
        bp_type[idx*4 +: 4] = t;
        bp_enable = '0;
        bp_enable[idx] = en;
        #1;
    endtask

    task automatic read_chk(input string req, input int idx, input logic [63:0] exp);
        rd_idx = 4'(idx);
        #1;
        chk(req, rd_data_o, exp);
    endtask

    task automatic hit_chk(input string req, input int idx, input logic exp);
        #1;
        chk(req, {63'h0, match_o[idx]}, {63'h0, exp});
    endtask

    task automatic t_reset;
        for (int i = 0; i < NB; i++) read_chk("R1 reset readback", i, 64'h0);
        chk("R1 reset match", {48'h0, match_o}, 64'h0);
    endtask

    task automatic t_write;
        setup(10, 4'b1110, 1'b0);
        write_slot(10, 64'hDEAD_BEEF_0123_4567);
        read_chk("R2 full readback", 10, 64'hDEAD_BEEF_0123_4567);
        read_chk("R2 neighbour untouched", 11, 64'h0);
    endtask

    task automatic t_unimpl;
        rd_idx = 4'd13;
        #1;
        chk("R3 rd_undef", {63'h0, rd_undef_o}, 64'h1);
        chk("R3 undef data", rd_data_o, 64'h0);
        rd_idx = 4'd11;
        #1;
        chk("R3 rd_undef low index", {63'h0, rd_undef_o}, 64'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        chk("R3 wr_undef", {63'h0, wr_undef_o}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        read_chk("R3 slot 10 unchanged", 10, 64'hDEAD_BEEF_0123_4567);
        read_chk("R3 slot 11 unchanged", 11, 64'h0);
        bp_enable = 16'hFFFF;
        #1;
        chk("R3 unbuilt slots silent", {60'h0, match_o[15:12]}, 64'h0);
        bp_enable = '0;
    endtask

    task automatic t_addr;
        setup(0, 4'b0000, 1'b1);
        write_slot(0, 64'h0000_0000_4000_1000);
        cur_addr = 64'h0000_0000_4000_1000;
        hit_chk("R6 exact address", 0, 1'b1);
        cur_addr = 64'hFFFE_0000_4000_1003;
        hit_chk("R6 low and sign bits ignored", 0, 1'b1);
        cur_addr = 64'h0000_0000_4000_1004;
        hit_chk("R6 bit 2 differs", 0, 1'b0);
        cur_addr = 64'h0000_8000_4000_1000;
        hit_chk("R6 bit 47 differs", 0, 1'b0);
        cur_addr = 64'h0004_0000_4000_1000;
        hit_chk("R7 bit 50 ignored", 0, 1'b1);
        bp_enable[0] = 1'b0;
        cur_addr = 64'h0000_0000_4000_1000;
        hit_chk("R4 disabled slot", 0, 1'b0);
        write_slot(0, 64'h0001_0000_0000_0003);
        read_chk("R8 sign copies set", 0, 64'hFFFF_0000_0000_0000);
        write_slot(0, 64'hFFF0_0000_0000_0010);
        read_chk("R8 sign copies clear", 0, 64'h0000_0000_0000_0010);
    endtask

    task automatic t_bit0;
        setup(0, 4'b0001, 1'b1);
        cur_addr = 64'h0000_0000_0000_0010;
        hit_chk("R5 address with bit0 set", 0, 1'b1);
        read_chk("R5 readback with bit0 set", 0, 64'h0000_0000_0000_0010);
    endtask

    task automatic t_ctx_auto;
        setup(1, 4'b0010, 1'b1);
        write_slot(1, 64'h1234_5678_AAAA_0001);
        ctx_l1 = 32'hAAAA_0001; ctx_l2 = 32'hBBBB_0002;
        host_ext_en = 1'b0; cur_el = 2'd2;
        hit_chk("R9 host off uses level 1", 1, 1'b1);
        host_ext_en = 1'b1;
        hit_chk("R9 host on level 2 uses level 2", 1, 1'b0);
        ctx_l2 = 32'hAAAA_0001; ctx_l1 = 32'h0;
        hit_chk("R9 level 2 context matches", 1, 1'b1);
        cur_el = 2'd0; trap_general = 1'b1; el2_enabled = 1'b1;
        hit_chk("R9 level 0 routed to level 2", 1, 1'b1);
        el2_enabled = 1'b0;
        hit_chk("R9 level 0 without level 2", 1, 1'b0);
        cur_el = 2'd1; el2_enabled = 1'b1;
        hit_chk("R9 level 1 uses level 1", 1, 1'b0);
        read_chk("R14 single context readback", 1, 64'h0000_0000_AAAA_0001);
    endtask

    task automatic t_ctx_fixed;
        host_ext_en = 1'b1; cur_el = 2'd2;
        setup(5, 4'b0110, 1'b1);
        write_slot(5, 64'h0000_0000_1111_2222);
        ctx_l1 = 32'h1111_2222; ctx_l2 = 32'h0;
        hit_chk("R10 type 011 level 1", 5, 1'b1);
        bp_type[20 +: 4] = 4'b0111;
        hit_chk("R5 type 011 with bit0 set", 5, 1'b1);
        setup(6, 4'b1100, 1'b1);
        write_slot(6, 64'h3333_4444_9999_9999);
        ctx_l2 = 32'h3333_4444;
        hit_chk("R10 type 110 upper word", 6, 1'b1);
        read_chk("R14 type 110 readback", 6, 64'h3333_4444_0000_0000);
        setup(7, 4'b1110, 1'b1);
        write_slot(7, 64'h5555_6666_7777_8888);
        ctx_l2 = 32'h5555_6666; ctx_l1 = 32'h7777_8888;
        hit_chk("R10 type 111 both match", 7, 1'b1);
        ctx_l1 = 32'h7777_8889;
        hit_chk("R10 type 111 level 1 differs", 7, 1'b0);
        host_ext_en = 1'b0; cur_el = 2'd1;
    endtask

    task automatic t_vmid;
        setup(3, 4'b1000, 1'b1);
        write_slot(3, 64'hFFFF_5A3C_1234_5678);
        cur_vmid = 16'h113C;
        hit_chk("R11 narrow VMID", 3, 1'b1);
        read_chk("R11 narrow readback", 3, 64'h0000_003C_0000_0000);
        vmid_wide_ctl = 1'b1; el2_is_64 = 1'b1;
        hit_chk("R11 wide VMID upper differs", 3, 1'b0);
        cur_vmid = 16'h5A3C;
        hit_chk("R11 wide VMID matches", 3, 1'b1);
        read_chk("R14 wide VMID readback", 3, 64'h0000_5A3C_0000_0000);
        el2_is_64 = 1'b0; cur_vmid = 16'h003C;
        hit_chk("R11 32-bit level 2 stays narrow", 3, 1'b1);
        vmid_wide_ctl = 1'b0;
    endtask

    task automatic t_vmid_ctx;
        setup(4, 4'b1010, 1'b1);
        write_slot(4, 64'h0000_0077_CAFE_0001);
        cur_vmid = 16'h0077; ctx_l1 = 32'hCAFE_0001;
        hit_chk("R12 both match", 4, 1'b1);
        read_chk("R14 VMID plus context readback", 4, 64'h0000_0077_CAFE_0001);
        ctx_l1 = 32'hCAFE_0002;
        hit_chk("R12 context differs", 4, 1'b0);
        ctx_l1 = 32'hCAFE_0001; cur_vmid = 16'h0078;
        hit_chk("R12 VMID differs", 4, 1'b0);
    endtask

    task automatic t_reserved;
        setup(8, 4'b0100, 1'b1);
        write_slot(8, 64'h0000_0000_0000_0000);
        cur_addr = '0; ctx_l1 = '0; ctx_l2 = '0; cur_vmid = '0;
        hit_chk("R13 reserved never matches", 8, 1'b0);
        write_slot(8, 64'h0123_4567_89AB_CDEF);
        read_chk("R13 reserved reads zero", 8, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_write();
        t_unimpl();
        t_addr();
        t_bit0();
        t_ctx_auto();
        t_ctx_fixed();
        t_vmid();
        t_vmid_ctx();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule